// File: doc/BRIEF.md
# Capture DMA Sequencer

This block moves 32-bit words from a capture FIFO into memory under control of a small program that it fetches from memory. Each instruction is a pair of 32-bit words, a command followed by an address operand. The command can write FIFO data to a given address, keep writing from where the last write stopped, throw FIFO data away, branch to another instruction, or wait for a FIFO word that carries a sync marker. A branch at the end of the list turns it into a ring that runs without further help from software.

Every command carries two 4-bit masks. When the command completes, the sequencer clears the bits of a program status nibble that one mask selects and then sets the bits that the other mask selects. It can also raise an interrupt. Software reads the nibble together with the sticky error and interrupt flags to learn how far the ring has progressed.

Software starts the engine by writing a start address and then setting the sequencer-enable bit. It stops the engine by clearing that bit. The FIFO, the memory bus and the front end sit outside this block and connect through plain valid/ready style ports.

Top module: `cdma_seq`

## Requirements
- R1: After reset the status word and the interrupt line are 0, and no fetch request or write is issued.
- R2: When the sequencer-enable bit (control bit 1) goes to 1, fetching starts at the start address with bits 1:0 forced to 0. Every fetch address is word aligned. The command word is fetched first and its operand follows at the next word address.
- R3: Opcode 0x1 (command bits 31:28) writes count/4 FIFO words, where the count is the byte count in command bits 11:0. The words go in FIFO order to the operand address and the addresses after it, stepping by 4.
- R4: Opcode 0x5 writes its count/4 FIFO words starting at the address that follows the last word written by the previous write command.
- R5: Opcode 0x2 takes count/4 FIFO words and issues no write.
- R6: Opcode 0x7 makes the next fetch come from its operand address.
- R7: Opcode 0x8 takes and discards FIFO words up to and including the first word whose sync marker is high.
- R8: When a command completes, the program status in status bits 31:28 becomes (old AND NOT clear-mask[23:20]) OR set-mask[19:16]. If command bit 24 is set, status bit 11 is also set.
- R9: Register select 0 holds the start address, 1 the control word, 2 the status word and 3 the mask. Writing 1 to a sticky status bit (11, 12, 14, 18) clears it. The interrupt line is the OR of the sticky bits ANDed with the mask.
- R10: A FIFO word taken by a write command while wr_ready is 0 sets status bit 12. The word is dropped, and neither the address nor the remaining count advances.
- R11: A word with the sync marker high that a write command accepts sets status bit 14, unless command bit 15 is set. The word is still written.
- R12: An undefined opcode sets status bit 18 and clears the running bit 27. No further fetch or write happens until the enable bit is cleared and set again.
- R13: One cycle after the enable bit is cleared, the running bit is 0 and no fetch is requested.
- R14: While the FIFO-enable bit (control bit 0) is 0, no FIFO word is taken and nothing is written. Once the bit is set, the pending transfer carries on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| int_stat | output | 32 | Status word: program status, running, sticky flags |
| irq | output | 1 | Interrupt request |
| if_req | output | 1 | Instruction fetch request |
| if_addr | output | AW | Instruction fetch byte address |
| if_ack | input | 1 | Fetch data valid this cycle |
| if_rdata | input | 32 | Fetched word |
| wr_valid | output | 1 | Data write valid |
| wr_addr | output | AW | Data write byte address |
| wr_data | output | 32 | Data write word |
| wr_ready | input | 1 | Write port accepts this cycle |
| fifo_valid | input | 1 | FIFO word present |
| fifo_data | input | 32 | FIFO word |
| fifo_sync | input | 1 | Sync marker of the FIFO word |
| fifo_ready | output | 1 | Word taken this cycle |

## Verification
The bench builds the block with a 16-bit address, which keeps the program, the data buffers and the expected addresses small and easy to read. The fetch responder answers in the same cycle, so every cycle of the fetch, execute and completion path is exercised back to back. A reference queue of expected writes, built from the program's meaning, is compared with every accepted write. One program chains all five opcodes, carries status masks through several completions, and ends in a branch to an illegal opcode with a trap write placed on the fall-through path. Separate runs cover the stalled write port, the sync marker inside a write, disabling mid-program and the FIFO gate.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam int CNT_W = 12;

    localparam logic [3:0] OP_WR   = 4'h1;
    localparam logic [3:0] OP_SKIP = 4'h2;
    localparam logic [3:0] OP_WRC  = 4'h5;
    localparam logic [3:0] OP_JMP  = 4'h7;
    localparam logic [3:0] OP_SYNC = 4'h8;

    localparam int B_IRQ     = 11;
    localparam int B_OVF_BUS = 12;
    localparam int B_OVF_TGT = 13;
    localparam int B_RESYNC  = 14;
    localparam int B_BADOP   = 18;
    localparam int B_RUN     = 27;
    localparam int B_PS      = 28;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_CTRL  = 2'd1;
    localparam logic [1:0] SEL_STAT  = 2'd2;
    localparam logic [1:0] SEL_MASK  = 2'd3;

    localparam logic [31:0] STICKY_M = (32'h1 << B_IRQ) | (32'h1 << B_OVF_BUS) |
                                       (32'h1 << B_RESYNC) | (32'h1 << B_BADOP);

    typedef struct packed {
        logic [3:0]       op;
        logic             sol;
        logic             eol;
        logic             rsv;
        logic             irq;
        logic [3:0]       clr;
        logic [3:0]       set;
        logic             rs_off;
        logic [2:0]       be;
        logic [CNT_W-1:0] cnt;
    } cmd_t;

    typedef enum logic [2:0] {S_IDLE, S_FCMD, S_FARG, S_EXEC, S_HALT} state_e;

    typedef struct packed {
        logic irq_req;
        logic ovf_bus;
        logic resync;
        logic badop;
    } ev_t;

    function automatic logic op_known(input logic [3:0] op);
        return op == OP_WR || op == OP_WRC || op == OP_SKIP || op == OP_JMP || op == OP_SYNC;
    endfunction

    function automatic logic is_xfer(input logic [3:0] op);
        return op == OP_WR || op == OP_WRC || op == OP_SKIP;
    endfunction

    function automatic logic is_write(input logic [3:0] op);
        return op == OP_WR || op == OP_WRC;
    endfunction

    function automatic logic [3:0] ps_next(input logic [3:0] ps, input cmd_t c);
        return (ps & ~c.clr) | c.set;
    endfunction

endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
    import cdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  ev_t           ev,
    input  logic          running,
    input  logic [3:0]    prog_status,
    output logic [AW-1:0] start_addr,
    output logic          seq_en,
    output logic          fifo_en,
    output logic [31:0]   int_stat,
    output logic          irq
);

    logic [AW-1:0] start_q;
    logic [1:0]    ctrl_q;
    logic [31:0]   sticky_q;
    logic [31:0]   mask_q;
    logic [31:0]   ev_vec;
    logic [31:0]   clr_vec;

    always_comb begin
        ev_vec = '0;
        ev_vec[B_IRQ]     = ev.irq_req;
        ev_vec[B_OVF_BUS] = ev.ovf_bus;
        ev_vec[B_RESYNC]  = ev.resync;
        ev_vec[B_BADOP]   = ev.badop;
        clr_vec = (reg_wr && reg_sel == SEL_STAT) ? (reg_wdata & STICKY_M) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= '0;
            ctrl_q   <= '0;
            sticky_q <= '0;
            mask_q   <= '0;
        end else begin
            if (reg_wr && reg_sel == SEL_START) start_q <= {reg_wdata[AW-1:2], 2'b00};
            if (reg_wr && reg_sel == SEL_CTRL)  ctrl_q  <= reg_wdata[1:0];
            if (reg_wr && reg_sel == SEL_MASK)  mask_q  <= reg_wdata & STICKY_M;
            sticky_q <= (sticky_q & ~clr_vec) | ev_vec;
        end
    end

    always_comb begin
        start_addr = start_q;
        seq_en     = ctrl_q[1];
        fifo_en    = ctrl_q[0];
        int_stat   = sticky_q;
        int_stat[B_RUN] = running;
        int_stat[31:B_PS] = prog_status;
        irq        = |(sticky_q & mask_q);
    end

    // R9: a write-one clear removes the interrupt flag unless a new one arrives
    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == SEL_STAT && reg_wdata[B_IRQ] && !ev.irq_req) |=> !int_stat[B_IRQ]);

endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
    import cdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          seq_en,
    input  logic          fifo_en,
    input  logic [AW-1:0] start_addr,
    output logic          if_req,
    output logic [AW-1:0] if_addr,
    input  logic          if_ack,
    input  logic [31:0]   if_rdata,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    input  logic          wr_ready,
    input  logic          fifo_valid,
    input  logic [31:0]   fifo_data,
    input  logic          fifo_sync,
    output logic          fifo_ready,
    output logic          running,
    output logic [3:0]    prog_status,
    output ev_t           ev
);

    localparam int WC_W = CNT_W - 2;
    localparam logic [AW-1:0] STEP = AW'(4);

    state_e        st;
    cmd_t          cmd;
    logic [AW-1:0] pc, cur, arg;
    logic [WC_W-1:0] wc;
    logic [3:0]    ps_q;
    logic          xfer_op, wr_op, sync_op, wc_zero, hs, finish;
    logic [AW-1:0] rd_aligned;

    always_comb begin
        xfer_op    = is_xfer(cmd.op);
        wr_op      = is_write(cmd.op);
        sync_op    = cmd.op == OP_SYNC;
        wc_zero    = wc == '0;
        fifo_ready = fifo_en && st == S_EXEC && ((xfer_op && !wc_zero) || sync_op);
        hs         = fifo_valid && fifo_ready;
        wr_valid   = hs && wr_op;
        wr_addr    = cur;
        wr_data    = fifo_data;
        if_req     = st == S_FCMD || st == S_FARG;
        if_addr    = pc;
        finish     = st == S_EXEC && ((xfer_op && wc_zero) || (sync_op && hs && fifo_sync)
                                      || cmd.op == OP_JMP);
        running    = st == S_FCMD || st == S_FARG || st == S_EXEC;
        rd_aligned = {if_rdata[AW-1:2], 2'b00};
        prog_status = ps_q;
        ev.irq_req = finish && cmd.irq;
        ev.ovf_bus = wr_valid && !wr_ready;
        ev.resync  = wr_valid && wr_ready && fifo_sync && !cmd.rs_off;
        ev.badop   = st == S_FARG && if_ack && !op_known(cmd.op);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            cmd  <= '0;
            pc   <= '0;
            cur  <= '0;
            arg  <= '0;
            wc   <= '0;
            ps_q <= '0;
        end else if (!seq_en) begin
            st <= S_IDLE;
        end else begin
            case (st)
                S_IDLE: begin
                    pc <= start_addr;
                    st <= S_FCMD;
                end
                S_FCMD: if (if_ack) begin
                    cmd <= cmd_t'(if_rdata);
                    pc  <= pc + STEP;
                    st  <= S_FARG;
                end
                S_FARG: if (if_ack) begin
                    arg <= rd_aligned;
                    pc  <= pc + STEP;
                    wc  <= cmd.cnt[CNT_W-1:2];
                    if (cmd.op == OP_WR) cur <= rd_aligned;
                    st  <= op_known(cmd.op) ? S_EXEC : S_HALT;
                end
                S_EXEC: begin
                    if (hs && xfer_op && (!wr_op || wr_ready)) wc <= wc - 1'b1;
                    if (hs && wr_op && wr_ready) cur <= cur + STEP;
                    if (finish) begin
                        ps_q <= ps_next(ps_q, cmd);
                        st   <= S_FCMD;
                        if (cmd.op == OP_JMP) pc <= arg;
                    end
                end
                default: ;
            endcase
        end
    end

    p_fetch_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        if_req |-> if_addr[1:0] == 2'b00);

    p_halt_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (st == S_HALT && seq_en) |=> (!if_req && !wr_valid));

    p_disable_idle_r13: assert property (@(posedge clk) disable iff (rst)
        !seq_en |=> !running);

    p_sync_waits_r7: assert property (@(posedge clk) disable iff (rst)
        (st == S_EXEC && sync_op && hs && !fifo_sync && seq_en) |=> st == S_EXEC);

    p_drop_holds_addr_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready && seq_en) |=> $stable(wr_addr));

endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
    import cdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   int_stat,
    output logic          irq,
    output logic          if_req,
    output logic [AW-1:0] if_addr,
    input  logic          if_ack,
    input  logic [31:0]   if_rdata,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    input  logic          wr_ready,
    input  logic          fifo_valid,
    input  logic [31:0]   fifo_data,
    input  logic          fifo_sync,
    output logic          fifo_ready
);

    ev_t           ev;
    logic          running, seq_en, fifo_en;
    logic [3:0]    prog_status;
    logic [AW-1:0] start_addr;

    cdma_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ev(ev), .running(running), .prog_status(prog_status), .start_addr(start_addr),
        .seq_en(seq_en), .fifo_en(fifo_en), .int_stat(int_stat), .irq(irq)
    );

    cdma_engine #(.AW(AW)) u_engine (
        .clk(clk), .rst(rst), .seq_en(seq_en), .fifo_en(fifo_en), .start_addr(start_addr),
        .if_req(if_req), .if_addr(if_addr), .if_ack(if_ack), .if_rdata(if_rdata),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_sync(fifo_sync),
        .fifo_ready(fifo_ready), .running(running), .prog_status(prog_status), .ev(ev)
    );

endmodule

// File: tb/tb_cdma_seq.sv
module tb_cdma_seq;

    localparam int AW = 16;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   int_stat;
    logic          irq;
    logic          if_req;
    logic [AW-1:0] if_addr;
    logic          if_ack;
    logic [31:0]   if_rdata = '0;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          wr_ready = 1'b1;
    logic          fifo_valid = 1'b0;
    logic [31:0]   fifo_data = '0;
    logic          fifo_sync = 1'b0;
    logic          fifo_ready;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign if_ack = if_req;

    cdma_seq #(.AW(AW)) dut (.*);

    typedef struct { logic [31:0] d; bit s; bit stall; } fw_t;
    typedef struct { logic [AW-1:0] a; logic [31:0] d; string tag; } ew_t;

    logic [31:0] mem [int];
    fw_t  fq[$];
    ew_t  eq[$];
    int   n_chk = 0, n_fail = 0, cyc = 0;
    bit   want_first = 0;
    logic [AW-1:0] exp_first = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] op, input bit sol, input bit eol, input bit irqb,
                                       input logic [3:0] clr, input logic [3:0] set, input bit rs,
                                       input logic [11:0] cnt);
        return {op, sol, eol, 1'b0, irqb, clr, set, rs, 3'b000, cnt};
    endfunction

    function automatic logic [31:0] rd(input logic [AW-1:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
    endfunction

    task automatic put(input int a, input logic [31:0] c, input logic [31:0] o);
        mem[a] = c;
        mem[a + 4] = o;
    endtask

    task automatic push(input logic [31:0] d, input bit s, input bit stall);
        fw_t w;
        w.d = d; w.s = s; w.stall = stall;
        fq.push_back(w);
    endtask

    task automatic expw(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        ew_t e;
        e.a = a; e.d = d; e.tag = tag;
        eq.push_back(e);
    endtask

    task automatic wreg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stimulus driver and reference comparison, once per cycle
    always @(negedge clk) begin
        if (fq.size() > 0) begin
            fifo_valid = 1'b1; fifo_data = fq[0].d; fifo_sync = fq[0].s; wr_ready = !fq[0].stall;
        end else begin
            fifo_valid = 1'b0; fifo_sync = 1'b0; wr_ready = 1'b1;
        end
        #2;
        if_rdata = rd(if_addr);
        if (if_req && want_first) begin
            chk(if_addr == exp_first, "R2 first fetch address", 32'(if_addr), 32'(exp_first));
            want_first = 0;
        end
        if (wr_valid && wr_ready) begin
            if (eq.size() == 0) begin
                chk(0, "R3 unexpected write", 32'(wr_addr), 32'hffffffff);
            end else begin
                chk(wr_addr == eq[0].a && wr_data == eq[0].d, {eq[0].tag, " write address"},
                    32'(wr_addr), 32'(eq[0].a));
                chk(wr_data == eq[0].d, {eq[0].tag, " write data"}, wr_data, eq[0].d);
                void'(eq.pop_front());
            end
        end
        if (fifo_valid && fifo_ready) void'(fq.pop_front());
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1
        chk(int_stat == 32'h0, "R1 status after reset", int_stat, 32'h0);
        chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
        chk(!if_req && !wr_valid, "R1 no activity after reset", 32'({if_req, wr_valid}), 32'h0);

        // Program chaining all opcodes: R3 R4 R5 R6 R7 R8 R12
        put(32'h100, mk(4'h1, 1, 0, 1, 4'h0, 4'h3, 0, 12'd12), 32'h2000);
        put(32'h108, mk(4'h5, 0, 0, 0, 4'h0, 4'h0, 0, 12'd8),  32'h0);
        put(32'h110, mk(4'h2, 0, 0, 0, 4'h0, 4'h0, 0, 12'd8),  32'h0);
        put(32'h118, mk(4'h1, 0, 0, 0, 4'hF, 4'h5, 0, 12'd4),  32'h3000);
        put(32'h120, mk(4'h8, 0, 0, 0, 4'h0, 4'h0, 0, 12'd0),  32'h0);
        put(32'h128, mk(4'h1, 0, 1, 1, 4'h1, 4'h8, 1, 12'd4),  32'h4000);
        put(32'h130, mk(4'h7, 0, 0, 0, 4'h0, 4'h0, 0, 12'd0),  32'h180);
        put(32'h138, mk(4'h1, 0, 0, 0, 4'h0, 4'h0, 0, 12'd4),  32'h4100);
        put(32'h180, 32'h0, 32'h0);
        push(32'hA0, 0, 0); push(32'hA1, 0, 0); push(32'hA2, 0, 0);
        push(32'hB0, 0, 0); push(32'hB1, 0, 0);
        push(32'h50, 0, 0); push(32'h51, 0, 0);
        push(32'hC0, 0, 0);
        push(32'h70, 0, 0); push(32'h71, 0, 0); push(32'h72, 1, 0);
        push(32'hD0, 1, 0);
        push(32'hE0, 0, 0);
        expw(16'h2000, 32'hA0, "R3"); expw(16'h2004, 32'hA1, "R3"); expw(16'h2008, 32'hA2, "R3");
        expw(16'h200C, 32'hB0, "R4"); expw(16'h2010, 32'hB1, "R4");
        expw(16'h3000, 32'hC0, "R5 skip then write");
        expw(16'h4000, 32'hD0, "R7 sync then write");
        wreg(2'd0, 32'h103);
        wreg(2'd3, 32'h1 << 11);
        exp_first = 16'h100; want_first = 1;
        wreg(2'd1, 32'h3);
        idle(2);
        chk(int_stat[27] == 1'b1, "R2 running after enable", 32'(int_stat[27]), 32'h1);
        idle(100);
        chk(eq.size() == 0, "R3 all expected writes seen", eq.size(), 0);
        chk(fq.size() == 1, "R6 jump skips fall-through write", fq.size(), 1);
        chk(int_stat == 32'hC004_0800, "R8 status nibble and interrupt flag", int_stat, 32'hC004_0800);
        chk(!if_req && !wr_valid, "R12 halted after undefined opcode", 32'({if_req, wr_valid}), 32'h0);
        chk(irq == 1'b1, "R9 irq from masked flag", 32'(irq), 32'h1);
        wreg(2'd2, 32'h1 << 11);
        chk(irq == 1'b0 && int_stat == 32'hC004_0000, "R9 write-one clear", int_stat, 32'hC004_0000);
        wreg(2'd3, 32'h1 << 18);
        chk(irq == 1'b1, "R9 mask selects bad opcode flag", 32'(irq), 32'h1);
        wreg(2'd1, 32'h0);
        wreg(2'd2, 32'h1 << 18);
        fq.delete();
        idle(2);

        // Stalled write port and sync marker inside a write: R10 R11, then disable R13
        put(32'h400, mk(4'h1, 0, 0, 0, 4'h0, 4'h0, 0, 12'd8), 32'h5000);
        put(32'h408, mk(4'h8, 0, 0, 0, 4'h0, 4'h0, 0, 12'd0), 32'h0);
        push(32'h11, 1, 0); push(32'h22, 0, 1); push(32'h33, 0, 0);
        expw(16'h5000, 32'h11, "R11 marked word still written");
        expw(16'h5004, 32'h33, "R10 address held after drop");
        wreg(2'd0, 32'h400);
        wreg(2'd1, 32'h3);
        idle(30);
        chk(eq.size() == 0, "R10 writes after dropped word", eq.size(), 0);
        chk(int_stat == 32'hC800_5000, "R10 R11 overrun and resync flags", int_stat, 32'hC800_5000);
        wreg(2'd1, 32'h0);
        idle(1);
        chk(int_stat[27] == 1'b0 && !if_req, "R13 idle after disable", int_stat, 32'hC000_5000);
        wreg(2'd2, 32'h0000_5000);

        // FIFO gate: R14
        put(32'h600, mk(4'h1, 0, 0, 0, 4'h0, 4'h0, 0, 12'd4), 32'h6000);
        put(32'h608, mk(4'h8, 0, 0, 0, 4'h0, 4'h0, 0, 12'd0), 32'h0);
        push(32'h66, 0, 0);
        expw(16'h6000, 32'h66, "R14 write after gate opens");
        wreg(2'd0, 32'h600);
        wreg(2'd1, 32'h2);
        idle(10);
        chk(fq.size() == 1 && eq.size() == 1, "R14 no word taken while gated", fq.size(), 1);
        chk(int_stat == 32'hC800_0000, "R14 no flags while gated", int_stat, 32'hC800_0000);
        wreg(2'd1, 32'h3);
        idle(10);
        chk(fq.size() == 0 && eq.size() == 0, "R14 transfer resumes", fq.size() + eq.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule